// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block sits between a register-access requester and a simple direct register port. Every request carries a 64-bit address, a 64-bit write data word and a read/write flag. When the top address bit is clear, the request goes to the direct port unchanged as a single access. When that bit is set, the request is indirect. The block then turns it into a short sequence of direct accesses and reports the outcome on its own completion strobe.

Two indirect formats exist, and address bit 60 selects between them. The polled format packs part of the request address into the data word and sends it to a low-31-bit direct address. It then reads back a status word from that same address. The reads stop when a done flag appears, when an error field is raised, or when the retry window runs out. The write-only format moves twelve upper address bits into the top of the data word and issues a single direct write. It refuses reads, and it refuses data whose top twelve bits are already in use.

The polling interval is a count of clock cycles, computed from the clock frequency parameter. Requests are accepted only while the block is idle.

Top module: `ind_reg_seq`

## Requirements
- R1: After reset, the block is idle. `req_ready` is 1, and `dp_req` and `done_valid` are 0.
- R2: A request with address bit 63 clear makes exactly one direct access. That access has the same op, the address bits 31:0 and the unchanged write data. A read returns `dp_rdata` on `done_rdata`, and the completion has code 0 (OK).
- R3: A polled request (bit 63 set, bit 60 clear) first issues a direct write to address bits 30:0, with bit 31 of `dp_addr` forced to 0. The data of that write is (request data AND 0xFFFF) OR (request address AND 0x001FFFFF00000000). Bit 63 of that data is 1 for a read and 0 for a write.
- R4: After the first write, the block reads the same direct address. The first read follows at once. Each further read comes CLK_MHZ*POLL_US idle cycles after the previous read's response. In the status word, bit 31 is done and bits 30:28 are the error field. Polling ends when done is set or the error field is nonzero.
- R5: For polled reads only, error value 1 (occupied) does not end polling, even together with done. For polled writes, any nonzero error ends polling.
- R6: At most LIMIT_US/POLL_US+1 status reads are made (11 by default). At the end, a nonzero error field gives code 2 (indirect fail). Otherwise a clear done gives code 3 (indirect timeout). Otherwise the code is 0.
- R7: A polled read that completes with code 0 returns status bits 15:0, zero-extended. Writes and failed requests return 0 on `done_rdata`.
- R8: A write-only-format read (bits 63 and 60 set) is rejected with code 4 and makes no direct access.
- R9: A write-only-format write whose data bits 63:52 are not all zero is rejected with code 5 and makes no direct access.
- R10: A write-only-format write makes one direct write to address bits 31:0. Its data is the request data with address bits 43:32 placed in data bits 63:52.
- R11: A direct-port error at any step ends the sequence at once with code 1 (bus error). No further access is made.
- R12: `dp_req` and its address, op and data stay stable until `dp_resp`. `req_ready` is low from acceptance until the completion. `done_valid` lasts exactly one cycle, and the block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken when `req_ready` is 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Request address; bit 63 indirect, bit 60 format |
| req_wdata | input | 64 | Request write data |
| req_ready | output | 1 | Block idle and able to take a request |
| done_valid | output | 1 | One-cycle completion strobe |
| done_code | output | 3 | Result code (0 OK, 1 bus, 2 fail, 3 timeout, 4 read reject, 5 data reject) |
| done_rdata | output | 64 | Read result |
| dp_req | output | 1 | Direct access request, held until `dp_resp` |
| dp_write | output | 1 | Direct access op, 1 = write |
| dp_addr | output | 32 | Direct access address |
| dp_wdata | output | 64 | Direct access write data |
| dp_resp | input | 1 | Direct access response strobe |
| dp_rdata | input | 64 | Direct access read data, valid with `dp_resp` |
| dp_err | input | 1 | Direct access error, valid with `dp_resp` |

## Verification
A rejected request completes one cycle after it is accepted. A direct or write-only access completes one cycle after its response. A polled request completes one cycle after the response to its final status read. With a responder that answers each request on the next falling edge, the delay from request to completion is 1, 2 or 4+(n-1)*(W+1) cycles, where n is the number of status reads and W is the interval in cycles. The bench works out this due cycle from the requirements for every request. On every cycle before it, the bench checks that no completion appears and that the block is busy. On the due cycle, it checks the strobe, the code and the data, and it checks every direct access against the expected order when that access is answered.

// File: rtl/ind_seq_pkg.sv
package ind_seq_pkg;

    localparam int ADDR_W       = 64;
    localparam int DATA_W       = 64;
    localparam int DP_ADDR_W    = 32;
    localparam int IND_FLAG_BIT = 63;
    localparam int FORM_BIT     = 60;
    localparam int DONE_BIT     = 31;
    localparam int ERR_HI       = 30;
    localparam int ERR_LO       = 28;
    localparam int ERR_W        = ERR_HI - ERR_LO + 1;
    localparam int FIELD_W      = 16;
    localparam int RELOC_W      = 12;
    localparam int RELOC_SRC_LO = 32;

    localparam logic [ERR_W-1:0]  ERR_OCCUPIED   = ERR_W'(1);
    localparam logic [DATA_W-1:0] POLL_ADDR_MASK = 64'h001F_FFFF_0000_0000;
    localparam logic [DATA_W-1:0] POLL_DATA_MASK = 64'h0000_0000_0000_FFFF;

    typedef enum logic [2:0] {
        RC_OK          = 3'd0,
        RC_BUS         = 3'd1,
        RC_IND_FAIL    = 3'd2,
        RC_IND_TIMEOUT = 3'd3,
        RC_RD_REJECT   = 3'd4,
        RC_DATA_REJECT = 3'd5
    } rc_e;

    typedef enum logic [1:0] {K_DIRECT, K_POLLED, K_WONLY, K_REJECT} kind_e;
    typedef enum logic [1:0] {PH_SINGLE, PH_SETUP, PH_POLL} phase_e;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

    typedef struct packed {
        logic                 write;
        logic [DP_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]    data;
    } dp_cmd_t;

    typedef struct packed {
        logic               done;
        logic [ERR_W-1:0]   err;
        logic [FIELD_W-1:0] field;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_polled(logic [ADDR_W-1:0] addr,
                                                      logic [DATA_W-1:0] wdata,
                                                      logic              rd);
        logic [DATA_W-1:0] w;
        w = (wdata & POLL_DATA_MASK) | (addr & POLL_ADDR_MASK);
        w[DATA_W-1] = rd;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_wonly(logic [ADDR_W-1:0] addr,
                                                     logic [DATA_W-1:0] wdata);
        return wdata | {addr[RELOC_SRC_LO+RELOC_W-1:RELOC_SRC_LO], {(DATA_W-RELOC_W){1'b0}}};
    endfunction

endpackage

// File: rtl/ind_seq_decode.sv
module ind_seq_decode
    import ind_seq_pkg::*;
(
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output kind_e             kind,
    output rc_e               reject_code,
    output dp_cmd_t           first_cmd
);

    always_comb begin
        kind            = K_DIRECT;
        reject_code     = RC_OK;
        first_cmd.write = write;
        first_cmd.addr  = addr[DP_ADDR_W-1:0];
        first_cmd.data  = wdata;
        if (addr[IND_FLAG_BIT]) begin
            if (!addr[FORM_BIT]) begin
                kind            = K_POLLED;
                first_cmd.write = 1'b1;
                first_cmd.addr  = {1'b0, addr[DP_ADDR_W-2:0]};
                first_cmd.data  = pack_polled(addr, wdata, !write);
            end else if (!write) begin
                kind        = K_REJECT;
                reject_code = RC_RD_REJECT;
            end else if (wdata[DATA_W-1:DATA_W-RELOC_W] != '0) begin
                kind        = K_REJECT;
                reject_code = RC_DATA_REJECT;
            end else begin
                kind           = K_WONLY;
                first_cmd.data = pack_wonly(addr, wdata);
            end
        end
    end

endmodule

// File: rtl/ind_seq_status.sv
module ind_seq_status
    import ind_seq_pkg::*;
(
    input  stat_t             st,
    input  logic              is_read,
    input  logic              last_poll,
    output logic              finish,
    output rc_e               code,
    output logic [DATA_W-1:0] rdata
);

    logic hit;
    logic stop;

    always_comb begin
        hit    = st.done || (st.err != '0);
        stop   = is_read ? (hit && (st.err != ERR_OCCUPIED)) : hit;
        finish = stop || last_poll;
    end

    always_comb begin
        rdata = '0;
        if (st.err != '0) begin
            code = RC_IND_FAIL;
        end else if (!st.done) begin
            code = RC_IND_TIMEOUT;
        end else begin
            code = RC_OK;
            if (is_read) rdata = {{(DATA_W-FIELD_W){1'b0}}, st.field};
        end
    end

endmodule

// File: rtl/ind_seq_timer.sv
module ind_seq_timer #(
    parameter int unsigned TICKS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(TICKS - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    AST_TIMER_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);  // R4

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
    import ind_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 200,
    parameter int unsigned POLL_US  = 10,
    parameter int unsigned LIMIT_US = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 done_valid,
    output logic [2:0]           done_code,
    output logic [DATA_W-1:0]    done_rdata,
    output logic                 dp_req,
    output logic                 dp_write,
    output logic [DP_ADDR_W-1:0] dp_addr,
    output logic [DATA_W-1:0]    dp_wdata,
    input  logic                 dp_resp,
    input  logic [DATA_W-1:0]    dp_rdata,
    input  logic                 dp_err
);

    localparam int unsigned WAIT_TICKS = CLK_MHZ * POLL_US;
    localparam int unsigned MAX_POLLS  = LIMIT_US / POLL_US + 1;
    localparam int          PCW        = $clog2(MAX_POLLS + 1);

    state_e            state;
    phase_e            phase;
    dp_cmd_t           cmd;
    logic              is_read;
    logic [PCW-1:0]    poll_cnt;
    rc_e               rc_q;
    logic [DATA_W-1:0] rdata_q;

    kind_e             dec_kind;
    rc_e               dec_reject;
    dp_cmd_t           dec_cmd;
    stat_t             st_in;
    logic              st_finish;
    rc_e               st_code;
    logic [DATA_W-1:0] st_rdata;
    logic              last_poll;
    logic              timer_start;
    logic              timer_expired;

    ind_seq_decode u_decode (
        .write       (req_write),
        .addr        (req_addr),
        .wdata       (req_wdata),
        .kind        (dec_kind),
        .reject_code (dec_reject),
        .first_cmd   (dec_cmd)
    );

    assign st_in = '{done:  dp_rdata[DONE_BIT],
                     err:   dp_rdata[ERR_HI:ERR_LO],
                     field: dp_rdata[FIELD_W-1:0]};
    assign last_poll = (poll_cnt == PCW'(MAX_POLLS - 1));

    ind_seq_status u_status (
        .st        (st_in),
        .is_read   (is_read),
        .last_poll (last_poll),
        .finish    (st_finish),
        .code      (st_code),
        .rdata     (st_rdata)
    );

    assign timer_start = (state == S_ISSUE) && dp_resp && !dp_err &&
                         (phase == PH_POLL) && !st_finish;

    ind_seq_timer #(.TICKS(WAIT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (timer_start),
        .expired (timer_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            phase    <= PH_SINGLE;
            cmd      <= '0;
            is_read  <= 1'b0;
            poll_cnt <= '0;
            rc_q     <= RC_OK;
            rdata_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        is_read  <= !req_write;
                        poll_cnt <= '0;
                        rdata_q  <= '0;
                        if (dec_kind == K_REJECT) begin
                            rc_q  <= dec_reject;
                            state <= S_RESP;
                        end else begin
                            cmd   <= dec_cmd;
                            phase <= (dec_kind == K_POLLED) ? PH_SETUP : PH_SINGLE;
                            state <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (dp_resp) begin
                        if (dp_err) begin
                            rc_q    <= RC_BUS;
                            rdata_q <= '0;
                            state   <= S_RESP;
                        end else begin
                            case (phase)
                                PH_SINGLE: begin
                                    rc_q    <= RC_OK;
                                    rdata_q <= cmd.write ? '0 : dp_rdata;
                                    state   <= S_RESP;
                                end
                                PH_SETUP: begin
                                    phase     <= PH_POLL;
                                    cmd.write <= 1'b0;
                                end
                                default: begin
                                    if (st_finish) begin
                                        rc_q    <= st_code;
                                        rdata_q <= st_rdata;
                                        state   <= S_RESP;
                                    end else begin
                                        poll_cnt <= poll_cnt + 1'b1;
                                        state    <= S_WAIT;
                                    end
                                end
                            endcase
                        end
                    end
                end
                S_WAIT: begin
                    if (timer_expired) state <= S_ISSUE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == S_IDLE);
    assign dp_req     = (state == S_ISSUE);
    assign dp_write   = cmd.write;
    assign dp_addr    = cmd.addr;
    assign dp_wdata   = cmd.data;
    assign done_valid = (state == S_RESP);
    assign done_code  = rc_q;
    assign done_rdata = rdata_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!dp_req && !done_valid));  // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dp_req && !dp_resp) |=> (dp_req && $stable(dp_addr) && $stable(dp_write) && $stable(dp_wdata)));  // R12

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));  // R12

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> (poll_cnt < PCW'(MAX_POLLS)));  // R6

    AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (done_valid && (done_code == RC_RD_REJECT || done_code == RC_DATA_REJECT)) |-> $past(req_ready));  // R8

    AST_BUS_STOP: assert property (@(posedge clk) disable iff (rst)
        (dp_req && dp_resp && dp_err) |=> (done_valid && done_code == RC_BUS));  // R11

endmodule

// File: tb/tb_ind_reg_seq.sv
module tb_ind_reg_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WAIT_C = 200 * 10;
    localparam int MAX_P  = 100 / 10 + 1;

    typedef struct packed {
        logic        wr;
        logic [31:0] a;
        logic [63:0] d;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready;
    logic        done_valid;
    logic [2:0]  done_code;
    logic [63:0] done_rdata;
    logic        dp_req;
    logic        dp_write;
    logic [31:0] dp_addr;
    logic [63:0] dp_wdata;
    logic        dp_resp = 1'b0;
    logic [63:0] dp_rdata = '0;
    logic        dp_err = 1'b0;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [63:0] rsp_q [$];
    acc_t        exp_acc [$];
    int          err_at = -1;
    int          acc_n = 0;
    string       cur_tag = "R1";

    always #2.5 clk = ~clk;

    ind_reg_seq dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .done_valid(done_valid), .done_code(done_code), .done_rdata(done_rdata),
        .dp_req(dp_req), .dp_write(dp_write), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .dp_resp(dp_resp), .dp_rdata(dp_rdata), .dp_err(dp_err)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Responder: answers each pending access on the next falling edge
    always @(negedge clk) begin : responder
        acc_t e;
        if (dp_resp) begin
            dp_resp  = 1'b0;
            dp_err   = 1'b0;
            dp_rdata = '0;
        end else if (dp_req) begin
            if (exp_acc.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected access", {31'b0, dp_write, dp_addr}, 64'h0);
            end else begin
                e = exp_acc.pop_front();
                chk(dp_write == e.wr && dp_addr == e.a, {cur_tag, " R3"}, "access op/address",
                    {31'b0, dp_write, dp_addr}, {31'b0, e.wr, e.a});
                if (e.wr) chk(dp_wdata == e.d, cur_tag, "access write data", dp_wdata, e.d);
            end
            dp_err   = (acc_n == err_at);
            dp_rdata = '0;
            if (!dp_write && rsp_q.size() > 0) dp_rdata = rsp_q.pop_front();
            acc_n++;
            dp_resp = 1'b1;
        end
    end

    task automatic ref_model(input bit wr, input logic [63:0] a, input logic [63:0] d,
                             input int e_at, input logic [63:0] rs [$],
                             output logic [2:0] code, output logic [63:0] rd, output int lat);
        acc_t        x;
        logic [63:0] p;
        logic [63:0] s;
        logic [2:0]  e;
        bit          dn;
        bit          hit;
        bit          stop;
        code = 3'd0; rd = '0; lat = 2;
        if (!a[63]) begin
            x.wr = wr; x.a = a[31:0]; x.d = d; exp_acc.push_back(x);
            if (e_at == 0) code = 3'd1;
            else if (!wr && rs.size() > 0) rd = rs[0];
        end else if (a[60]) begin
            if (!wr) begin
                code = 3'd4; lat = 1;
            end else if (d[63:52] != 12'h0) begin
                code = 3'd5; lat = 1;
            end else begin
                x.wr = 1'b1; x.a = a[31:0]; x.d = d | {a[43:32], 52'h0};
                exp_acc.push_back(x);
                if (e_at == 0) code = 3'd1;
            end
        end else begin
            p = (d & 64'hFFFF) | (a & 64'h001F_FFFF_0000_0000);
            p[63] = !wr;
            x.wr = 1'b1; x.a = {1'b0, a[30:0]}; x.d = p; exp_acc.push_back(x);
            if (e_at == 0) begin
                code = 3'd1;
            end else begin
                for (int n = 1; n <= MAX_P; n++) begin
                    x.wr = 1'b0; x.d = '0; exp_acc.push_back(x);
                    lat = 4 + (n - 1) * (WAIT_C + 1);
                    if (e_at == n) begin
                        code = 3'd1;
                        break;
                    end
                    s = (n - 1 < rs.size()) ? rs[n-1] : 64'h0;
                    dn = s[31]; e = s[30:28];
                    hit = dn || (e != 3'd0);
                    stop = wr ? hit : (hit && e != 3'd1);
                    if (stop || n == MAX_P) begin
                        code = (e != 3'd0) ? 3'd2 : (!dn ? 3'd3 : 3'd0);
                        if (code == 3'd0 && !wr) rd = {48'h0, s[15:0]};
                        break;
                    end
                end
            end
        end
    endtask

    task automatic txn(string tag, bit wr, logic [63:0] a, logic [63:0] d, int e_at);
        logic [2:0]  ecode;
        logic [63:0] erd;
        logic [63:0] rcopy [$];
        int          elat;
        int          lat;
        cur_tag = tag;
        exp_acc.delete();
        err_at = e_at;
        acc_n  = 0;
        rcopy  = rsp_q;
        ref_model(wr, a, d, e_at, rcopy, ecode, erd, elat);
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready before request", {63'h0, req_ready}, 64'h1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (lat < elat) begin
            chk(!done_valid && !req_ready, {tag, " R12"}, "busy without completion",
                {62'h0, done_valid, req_ready}, 64'h0);
            @(negedge clk);
            lat++;
        end
        chk(done_valid == 1'b1, tag, "completion on due cycle", {63'h0, done_valid}, 64'h1);
        chk(done_code == ecode, tag, "result code", {61'h0, done_code}, {61'h0, ecode});
        chk(done_rdata == erd, tag, "result data", done_rdata, erd);
        @(negedge clk);
        chk(!done_valid && req_ready, {tag, " R12"}, "idle after completion",
            {62'h0, done_valid, req_ready}, 64'h1);
        chk(exp_acc.size() == 0, tag, "all expected accesses made", 64'(exp_acc.size()), 64'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !dp_req && !done_valid, "R1", "idle after reset",
            {61'h0, req_ready, dp_req, done_valid}, 64'h4);

        rsp_q.delete();
        txn("R2 direct write", 1'b1, 64'h7FFF_0000_CAFE_0010, 64'h0123_4567_89AB_CDEF, -1);
        rsp_q.delete(); rsp_q.push_back(64'hDEAD_BEEF_CAFE_F00D);
        txn("R2 direct read", 1'b0, 64'h1234_5678_0000_0ABC, 64'h0, -1);

        rsp_q.delete(); rsp_q.push_back(64'h0000_0000_8000_0000);
        txn("R3 R4 polled write first poll", 1'b1, 64'h8005_A5A5_1234_5678, 64'hFFFF_FFFF_FFFF_BEEF, -1);
        rsp_q.delete(); rsp_q.push_back(64'h0); rsp_q.push_back(64'h0);
        rsp_q.push_back(64'h1234_0000_8000_1234);
        txn("R4 R7 polled read third poll", 1'b0, 64'h8FF0_0001_FFFF_FFFF, 64'h5555_5555_5555_AAAA, -1);

        rsp_q.delete(); rsp_q.push_back(64'h1000_0000); rsp_q.push_back(64'h9000_0000);
        rsp_q.push_back(64'h8000_55AA);
        txn("R5 occupied read keeps polling", 1'b0, 64'h8000_0002_0000_0040, 64'h0, -1);
        rsp_q.delete(); rsp_q.push_back(64'h1000_0000);
        txn("R5 occupied write stops", 1'b1, 64'h8000_0002_0000_0040, 64'h0000_0000_0000_1111, -1);

        rsp_q.delete(); rsp_q.push_back(64'h3000_0000);
        txn("R6 polled read error", 1'b0, 64'h8000_0003_0000_0080, 64'h0, -1);
        rsp_q.delete();
        txn("R6 polled read timeout", 1'b0, 64'h8000_0003_0000_0080, 64'h0, -1);
        rsp_q.delete();
        txn("R6 R7 polled write timeout", 1'b1, 64'h8000_0004_0000_0100, 64'h0000_0000_0000_2222, -1);

        rsp_q.delete();
        txn("R8 write-only read rejected", 1'b0, 64'h9000_0ABC_8765_4321, 64'h0, -1);
        txn("R9 write-only data rejected", 1'b1, 64'h9000_0ABC_8765_4321, 64'h0010_0000_0000_0000, -1);
        txn("R10 write-only write", 1'b1, 64'h9000_0ABC_8765_4321, 64'h000F_FFFF_0000_1111, -1);

        txn("R11 bus error direct", 1'b1, 64'h0000_0000_0000_0044, 64'h1, 0);
        txn("R11 bus error setup", 1'b0, 64'h8000_0001_0000_0004, 64'h0, 0);
        rsp_q.delete(); rsp_q.push_back(64'h0); rsp_q.push_back(64'h8000_0000);
        txn("R11 bus error second poll", 1'b0, 64'h8000_0001_0000_0004, 64'h0, 2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule